// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs master-side I2C transfers one byte and one bit slot at a time. Software writes an address word, a byte count and a command. The sequencer then issues start, address, data, acknowledge and stop requests to a bit-level shifter. The shifter answers each request with a done pulse, the sampled bit and an arbitration-lost indication. Outgoing bytes come from a transmit FIFO and incoming bytes go into a receive FIFO. Both FIFOs are 16 entries deep by default and can be cleared on their own.

A transfer can end with an automatic stop, or it can keep the bus held so that a later stop command or a repeated start continues it. Two policy inputs decide what happens when the transmit FIFO runs dry or the receive FIFO fills during a transfer: the bus stalls until the FIFO recovers, or the transfer is ended with a stop. A cancel command abandons a transfer at the next bit-slot boundary and releases the bus if it is held.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset `st_idle`=1, all error flags are 0, `st_tx_not_full`=1, `st_rx_not_empty`=0 and `bit_op`=0. The `bit_op` codes are 0 none, 1 start, 2 stop, 3 write bit, 4 read bit. A request stays unchanged until `bit_done` is seen, and `bit_op` is 0 while idle.
- R2: The command codes are 3'b000 start, 3'b010 stop, 3'b011 start with automatic stop, and any code with bit 2 set for cancel. A write with auto-stop sends the 7-bit header `addr_reg[7:0]` and then each FIFO byte MSB first, ends with one stop, and returns to idle.
- R3: `addr_reg[0]`=1 selects a read. Each received byte is pushed to the receive FIFO. The master acknowledges (drives 0 on the acknowledge slot) every byte except the last counted one, which it answers with 1.
- R4: `addr_reg[15]`=1 selects 10-bit addressing, with the address in `addr_reg[10:1]`. A write sends the header {5'b11110, a[9:8], 0} and then the low address byte.
- R5: A 10-bit read sends the header and the low byte, then a repeated start, then the header with the direction bit set to 1.
- R6: Start without auto-stop leaves the bus held after the last byte with no stop. A later stop command issues exactly one stop.
- R7: An address NACK sets `st_addr_nack`, sends stop, and returns to idle with the FIFO data unsent. Error flags clear on the next command.
- R8: A data NACK sets `st_data_nack` and sends stop, and no further bytes are sent.
- R9: Arbitration loss on a write bit sets `st_arb_lost` and returns to idle with no stop.
- R10: If the transmit FIFO is empty while bytes remain, the bus stalls with `bit_op`=0 when `tx_empty_end`=0 and resumes on push. When `tx_empty_end`=1 the transfer ends with a stop.
- R11: If the receive FIFO is full before a byte, the bus stalls until a pop when `rx_full_end`=0, and ends with a stop when `rx_full_end`=1.
- R12: Cancel during a transfer issues a stop at the next bit-slot boundary if the bus is held, then returns to idle.
- R13: `st_tx_not_full` drops at 16 entries and pushes to a full FIFO are dropped. `tx_clear` empties the transmit FIFO.
- R14: A word count of 0 sends only the address header and then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command code |
| addr_reg | input | 16 | Direction bit 0, address from bit 1, bit 15 selects 10-bit |
| word_count | input | 11 | Bytes in the transfer |
| tx_empty_end | input | 1 | 1: end the transfer when the TX FIFO is empty; 0: stall |
| rx_full_end | input | 1 | 1: end the transfer when the RX FIFO is full; 0: stall |
| tx_push | input | 1 | Push strobe for the TX FIFO |
| tx_data | input | 8 | TX byte |
| tx_clear | input | 1 | Flush the TX FIFO |
| rx_pop | input | 1 | Pop strobe for the RX FIFO |
| rx_data | output | 8 | RX FIFO head byte |
| rx_clear | input | 1 | Flush the RX FIFO |
| st_idle | output | 1 | Sequencer idle |
| st_arb_lost | output | 1 | Sticky arbitration-lost flag |
| st_addr_nack | output | 1 | Sticky address-NACK flag |
| st_data_nack | output | 1 | Sticky data-NACK flag |
| st_tx_not_full | output | 1 | TX FIFO has room |
| st_rx_not_empty | output | 1 | RX FIFO holds data |
| bit_op | output | 3 | Bit-level request code |
| bit_wval | output | 1 | Bit value for a write request |
| bit_done | input | 1 | Shifter completed the request |
| bit_rval | input | 1 | Sampled bit of a read request |
| bit_lost | input | 1 | Arbitration lost on this write bit |

## Verification
The assertions check on every cycle that:
- a bit request holds steady until its done pulse;
- the shifter sees no request while the sequencer is idle;
- at most one error flag is set at a time;
- an address NACK leads straight into a stop;
- arbitration loss drops to idle;
- a cancel issued during a stall yields a stop or idle on the next cycle.

Only the bench's scenarios can show the byte order on the bus, the header formats for the two address widths, the acknowledge pattern on reads, and the stall and end behaviour of the FIFO policies. The same holds for the held-bus case and for the count of stops in each transfer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_STOP  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4
    } bit_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ABIT, S_AACK, S_DCHK,
        S_WBIT, S_WACK, S_RBIT, S_RACK, S_STOP
    } seq_state_t;

    typedef struct packed {
        logic arb;
        logic anack;
        logic dnack;
    } err_flags_t;

    localparam logic [1:0] CMD_START      = 2'b00;
    localparam logic [1:0] CMD_STOP       = 2'b10;
    localparam logic [1:0] CMD_START_STOP = 2'b11;

    // Address byte for a given header step.
    function automatic logic [7:0] addr_byte(input logic [15:0] a, input logic [1:0] step);
        if (!a[15]) return a[7:0];
        case (step)
            2'd0:    return {5'b11110, a[10:9], 1'b0};
            2'd1:    return a[8:1];
            default: return {5'b11110, a[10:9], 1'b1};
        endcase
    endfunction

    // Index of the final header step.
    function automatic logic [1:0] last_step(input logic [15:0] a);
        if (!a[15]) return 2'd0;
        return a[0] ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CAP);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= wdata;
                wptr      <= wptr + 1'b1;
            end
            if (do_pop) rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [2:0]    cmd_code,
    input  logic [15:0]   addr_reg,
    input  logic [CW-1:0] word_count,
    input  logic          tx_empty_end,
    input  logic          rx_full_end,
    input  logic          tx_push,
    input  logic [7:0]    tx_data,
    input  logic          tx_clear,
    input  logic          rx_pop,
    output logic [7:0]    rx_data,
    input  logic          rx_clear,
    output logic          st_idle,
    output logic          st_arb_lost,
    output logic          st_addr_nack,
    output logic          st_data_nack,
    output logic          st_tx_not_full,
    output logic          st_rx_not_empty,
    output logic [2:0]    bit_op,
    output logic          bit_wval,
    input  logic          bit_done,
    input  logic          bit_rval,
    input  logic          bit_lost
);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_t    state;
    err_flags_t    errs;
    bit_op_t       op;
    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic [CW-1:0] left;
    logic [15:0]   addr_q;
    logic [1:0]    step;
    logic          owned, auto_stop, cancel_pend;
    logic          go, cancel_now, cancel_hit, lost_hit;
    logic          tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [7:0]    tx_head;

    i2cs_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_clear), .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    i2cs_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_clear), .push(rx_push), .wdata({sh[6:0], bit_rval}),
        .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
    );

    always_comb begin
        op       = OP_NONE;
        bit_wval = 1'b0;
        case (state)
            S_START:                 op = OP_START;
            S_ABIT, S_WBIT: begin    op = OP_WRITE; bit_wval = sh[7]; end
            S_AACK, S_WACK, S_RBIT:  op = OP_READ;
            S_RACK: begin            op = OP_WRITE; bit_wval = (left == ONE); end
            S_STOP:                  op = OP_STOP;
            default: ;
        endcase
    end

    assign go         = (op == OP_NONE) || bit_done;
    assign cancel_now = cmd_we && cmd_code[2];
    assign cancel_hit = (cancel_pend || cancel_now) && go &&
                        (state != S_IDLE) && (state != S_STOP);
    assign lost_hit   = bit_done && bit_lost && (op == OP_WRITE);
    assign tx_pop     = (state == S_DCHK) && !addr_q[0] && (left != '0) &&
                        !tx_empty && !cancel_hit;
    assign rx_push    = (state == S_RBIT) && bit_done && (bitn == 3'd7) && !cancel_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            errs        <= '0;
            sh          <= '0;
            bitn        <= '0;
            left        <= '0;
            addr_q      <= '0;
            step        <= '0;
            owned       <= 1'b0;
            auto_stop   <= 1'b0;
            cancel_pend <= 1'b0;
        end else begin
            if (cmd_we) errs <= '0;
            if (cancel_now && state != S_IDLE) cancel_pend <= 1'b1;
            if (state == S_IDLE) begin
                cancel_pend <= 1'b0;
                if (cmd_we) begin
                    if (cmd_code[2] || cmd_code[1:0] == CMD_STOP) begin
                        if (owned) state <= S_STOP;
                    end else if (cmd_code[1:0] == CMD_START ||
                                 cmd_code[1:0] == CMD_START_STOP) begin
                        addr_q    <= addr_reg;
                        left      <= word_count;
                        auto_stop <= cmd_code[0];
                        step      <= 2'd0;
                        state     <= S_START;
                    end
                end
            end else if (lost_hit) begin
                errs.arb    <= 1'b1;
                owned       <= 1'b0;
                cancel_pend <= 1'b0;
                state       <= S_IDLE;
            end else if (cancel_hit) begin
                cancel_pend <= 1'b0;
                if (state == S_START) owned <= 1'b1;
                state <= (owned || state == S_START) ? S_STOP : S_IDLE;
            end else if (go) begin
                case (state)
                    S_START: begin
                        owned <= 1'b1;
                        sh    <= addr_byte(addr_q, step);
                        bitn  <= '0;
                        state <= S_ABIT;
                    end
                    S_ABIT, S_WBIT: begin
                        sh   <= {sh[6:0], 1'b0};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= (state == S_ABIT) ? S_AACK : S_WACK;
                    end
                    S_AACK: begin
                        if (bit_rval) begin
                            errs.anack <= 1'b1;
                            state      <= S_STOP;
                        end else if (step == last_step(addr_q)) begin
                            state <= S_DCHK;
                        end else if (step == 2'd1) begin
                            step  <= 2'd2;
                            state <= S_START;
                        end else begin
                            step  <= step + 1'b1;
                            sh    <= addr_byte(addr_q, step + 1'b1);
                            bitn  <= '0;
                            state <= S_ABIT;
                        end
                    end
                    S_DCHK: begin
                        if (left == '0) begin
                            state <= auto_stop ? S_STOP : S_IDLE;
                        end else if (!addr_q[0]) begin
                            if (!tx_empty) begin
                                sh    <= tx_head;
                                bitn  <= '0;
                                state <= S_WBIT;
                            end else if (tx_empty_end) begin
                                state <= S_STOP;
                            end
                        end else begin
                            if (!rx_full) begin
                                bitn  <= '0;
                                state <= S_RBIT;
                            end else if (rx_full_end) begin
                                state <= S_STOP;
                            end
                        end
                    end
                    S_WACK: begin
                        left <= left - 1'b1;
                        if (bit_rval) begin
                            errs.dnack <= 1'b1;
                            state      <= S_STOP;
                        end else begin
                            state <= S_DCHK;
                        end
                    end
                    S_RBIT: begin
                        sh   <= {sh[6:0], bit_rval};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= S_RACK;
                    end
                    S_RACK: begin
                        left  <= left - 1'b1;
                        state <= S_DCHK;
                    end
                    S_STOP: begin
                        owned <= 1'b0;
                        state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign bit_op          = op;
    assign st_idle         = (state == S_IDLE);
    assign st_arb_lost     = errs.arb;
    assign st_addr_nack    = errs.anack;
    assign st_data_nack    = errs.dnack;
    assign st_tx_not_full  = !tx_full;
    assign st_rx_not_empty = !rx_empty;
endmodule

// File: rtl/i2cs_checks.sv
module i2cs_checks (
    input logic       clk,
    input logic       rst,
    input logic       cmd_we,
    input logic [2:0] cmd_code,
    input logic       st_idle,
    input logic       st_arb_lost,
    input logic       st_addr_nack,
    input logic       st_data_nack,
    input logic [2:0] bit_op,
    input logic       bit_done
);
    a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
        (bit_op != 3'd0 && !bit_done) |=> (bit_op == $past(bit_op)));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> (bit_op == 3'd0));

    a_r7_single_err: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_arb_lost, st_addr_nack, st_data_nack}));

    a_r7_nack_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(st_addr_nack) |-> (bit_op == 3'd2));

    a_r9_arb_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(st_arb_lost) |-> st_idle);

    a_r12_cancel_prompt: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_code[2] && bit_op == 3'd0 && !st_idle) |=>
        (bit_op == 3'd2 || st_idle));
endmodule

bind i2c_xfer_seq i2cs_checks u_checks (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .st_idle(st_idle), .st_arb_lost(st_arb_lost), .st_addr_nack(st_addr_nack),
    .st_data_nack(st_data_nack), .bit_op(bit_op), .bit_done(bit_done)
);

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_we = 0; logic [2:0] cmd_code = 0; logic [15:0] addr_reg = 0;
    logic [10:0] word_count = 0; logic tx_empty_end = 0, rx_full_end = 0;
    logic tx_push = 0; logic [7:0] tx_data = 0; logic tx_clear = 0;
    logic rx_pop = 0; logic [7:0] rx_data; logic rx_clear = 0;
    logic st_idle, st_arb_lost, st_addr_nack, st_data_nack, st_tx_not_full, st_rx_not_empty;
    logic [2:0] bit_op; logic bit_wval;
    logic bit_done = 0, bit_rval = 0, bit_lost = 0;

    always #4 clk = ~clk;

    i2c_xfer_seq dut (.*);

    int tests = 0, fails = 0, cycles = 0;
    int nb, nrdb, n_start, n_stop, nwbit, bitpos, rbit, nack_at, arb_at;
    bit ack_pending, expect_mack;
    logic [7:0] cur, blog [64];
    logic acklog [64];

    function automatic logic [7:0] rdv(input int i);
        return 8'hA0 + 8'(i * 7);
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                summary();
            end
        end
    end

    // Shifter and slave model.
    initial begin : shifter
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (bit_done) begin
                bit_done = 0; bit_lost = 0; cnt = 0;
            end else if (bit_op != 3'd0) begin
                cnt++;
                if (cnt == 2) begin
                    bit_done = 1;
                    case (bit_op)
                        3'd1: begin n_start++; bitpos = 0; end
                        3'd2: n_stop++;
                        3'd3: begin
                            nwbit++;
                            bit_lost = (nwbit == arb_at);
                            if (expect_mack) begin
                                acklog[nrdb-1] = bit_wval; expect_mack = 0;
                            end else begin
                                cur = {cur[6:0], bit_wval}; bitpos++;
                                if (bitpos == 8) begin
                                    blog[nb] = cur; nb++; bitpos = 0; ack_pending = 1;
                                end
                            end
                        end
                        default: begin
                            if (ack_pending) begin
                                bit_rval = (nb - 1 == nack_at); ack_pending = 0;
                            end else begin
                                bit_rval = rdv(nrdb)[7 - rbit]; rbit++;
                                if (rbit == 8) begin rbit = 0; nrdb++; expect_mack = 1; end
                            end
                        end
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        nb = 0; nrdb = 0; n_start = 0; n_stop = 0; nwbit = 0; bitpos = 0; rbit = 0;
        nack_at = -1; arb_at = -1; ack_pending = 0; expect_mack = 0;
        tx_empty_end = 0; rx_full_end = 0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_push = 1; tx_data = b;
        @(negedge clk); tx_push = 0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        @(negedge clk); b = rx_data; rx_pop = 1;
        @(negedge clk); rx_pop = 0;
    endtask

    task automatic issue(input logic [2:0] code, input logic [15:0] a, input int n);
        @(negedge clk); addr_reg = a; word_count = 11'(n); cmd_code = code; cmd_we = 1;
        @(negedge clk); cmd_we = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && !st_idle; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drain_rx(output int n);
        logic [7:0] b;
        n = 0;
        while (st_rx_not_empty) begin pop_rx(b); n++; end
    endtask

    task automatic t_reset();
        chk("R1 idle", st_idle, 1);
        chk("R1 flags", {st_arb_lost, st_addr_nack, st_data_nack}, 0);
        chk("R1 fifo flags", {st_tx_not_full, st_rx_not_empty}, 2'b10);
        chk("R1 op", bit_op, 0);
    endtask

    task automatic t_wr7();
        clr_log();
        push_tx(8'h30); push_tx(8'h31); push_tx(8'h32);
        issue(3'b011, 16'h00A4, 3); wait_idle();
        chk("R2 bytes", nb, 4);
        chk("R2 header", blog[0], 8'hA4);
        chk("R2 data order", {blog[1], blog[2], blog[3]}, 24'h303132);
        chk("R2 stop", n_stop, 1);
        chk("R2 idle", st_idle, 1);
    endtask

    task automatic t_rd7();
        logic [7:0] b;
        clr_log();
        issue(3'b011, 16'h0053, 3); wait_idle();
        chk("R3 header", blog[0], 8'h53);
        pop_rx(b); chk("R3 byte0", b, 8'hA0);
        pop_rx(b); chk("R3 byte1", b, 8'hA7);
        pop_rx(b); chk("R3 byte2", b, 8'hAE);
        chk("R3 acks", {acklog[0], acklog[1], acklog[2]}, 3'b001);
        chk("R3 stop", n_stop, 1);
    endtask

    task automatic t_wr10();
        clr_log();
        push_tx(8'h30);
        issue(3'b011, 16'h858A, 1); wait_idle();
        chk("R4 bytes", nb, 3);
        chk("R4 header and low", {blog[0], blog[1], blog[2]}, 24'hF4C530);
    endtask

    task automatic t_rd10();
        logic [7:0] b;
        clr_log();
        issue(3'b011, 16'h858B, 2); wait_idle();
        chk("R5 header seq", {blog[0], blog[1], blog[2]}, 24'hF4C5F5);
        chk("R5 starts", n_start, 2);
        pop_rx(b); chk("R5 byte0", b, 8'hA0);
        chk("R5 acks", {acklog[0], acklog[1]}, 2'b01);
        rx_clear = 1; @(negedge clk); rx_clear = 0;
    endtask

    task automatic t_hold();
        clr_log();
        push_tx(8'h44);
        issue(3'b000, 16'h00A4, 1); wait_idle();
        chk("R6 no stop while held", n_stop, 0);
        chk("R6 sent", nb, 2);
        issue(3'b010, 16'h0, 0); wait_idle();
        chk("R6 stop after cmd", n_stop, 1);
    endtask

    task automatic t_anack();
        clr_log(); nack_at = 0;
        push_tx(8'h11); push_tx(8'h12);
        issue(3'b011, 16'h00A4, 2); wait_idle();
        chk("R7 flag", st_addr_nack, 1);
        chk("R7 stop", n_stop, 1);
        chk("R7 only header", nb, 1);
        issue(3'b010, 16'h0, 0); wait_idle();
        chk("R7 flag cleared", st_addr_nack, 0);
        tx_clear = 1; @(negedge clk); tx_clear = 0;
    endtask

    task automatic t_dnack();
        clr_log(); nack_at = 1;
        push_tx(8'h21); push_tx(8'h22); push_tx(8'h23);
        issue(3'b011, 16'h00A4, 3); wait_idle();
        chk("R8 flag", st_data_nack, 1);
        chk("R8 bytes", nb, 2);
        chk("R8 stop", n_stop, 1);
        tx_clear = 1; @(negedge clk); tx_clear = 0;
    endtask

    task automatic t_arb();
        clr_log(); arb_at = 3;
        push_tx(8'h55);
        issue(3'b011, 16'h00A4, 1); wait_idle();
        chk("R9 flag", st_arb_lost, 1);
        chk("R9 no stop", n_stop, 0);
        chk("R9 idle", st_idle, 1);
        tx_clear = 1; @(negedge clk); tx_clear = 0;
    endtask

    task automatic t_txstall();
        clr_log();
        push_tx(8'h61);
        issue(3'b011, 16'h00A4, 2);
        for (int i = 0; i < 2000 && nb < 2; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R10 stalled op", bit_op, 0);
        chk("R10 stalled busy", st_idle, 0);
        push_tx(8'h62); wait_idle();
        chk("R10 resumed bytes", nb, 3);
        chk("R10 resumed data", blog[2], 8'h62);
        clr_log(); tx_empty_end = 1;
        push_tx(8'h71);
        issue(3'b011, 16'h00A4, 3); wait_idle();
        chk("R10 end bytes", nb, 2);
        chk("R10 end stop", n_stop, 1);
    endtask

    task automatic t_rxfull();
        logic [7:0] b;
        int n;
        clr_log(); rx_full_end = 1;
        issue(3'b011, 16'h0053, 20); wait_idle();
        chk("R11 end stop", n_stop, 1);
        drain_rx(n); chk("R11 end count", n, 16);
        clr_log();
        issue(3'b011, 16'h0053, 18);
        for (int i = 0; i < 8000 && nrdb < 16; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R11 stall busy", st_idle, 0);
        chk("R11 stall count", nrdb, 16);
        pop_rx(b); chk("R11 first", b, 8'hA0);
        for (int i = 0; i < 3; i++) pop_rx(b);
        wait_idle();
        drain_rx(n); chk("R11 total", n + 4, 18);
        chk("R11 last nack", {acklog[15], acklog[17]}, 2'b01);
    endtask

    task automatic t_cancel();
        clr_log();
        push_tx(8'h81);
        issue(3'b011, 16'h00A4, 5);
        for (int i = 0; i < 2000 && nb < 2; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        issue(3'b100, 16'h0, 0);
        repeat (20) @(negedge clk);
        chk("R12 idle", st_idle, 1);
        chk("R12 stop", n_stop, 1);
    endtask

    task automatic t_fifo();
        clr_log();
        for (int i = 0; i < 16; i++) push_tx(8'(i));
        chk("R13 full", st_tx_not_full, 0);
        push_tx(8'hEE);
        tx_clear = 1; @(negedge clk); tx_clear = 0;
        chk("R13 cleared", st_tx_not_full, 1);
        push_tx(8'h99);
        issue(3'b011, 16'h00A4, 1); wait_idle();
        chk("R13 fresh byte", blog[1], 8'h99);
    endtask

    task automatic t_zero();
        clr_log();
        issue(3'b011, 16'h00A4, 0); wait_idle();
        chk("R14 bytes", nb, 1);
        chk("R14 stop", n_stop, 1);
    endtask

    initial begin
        clr_log();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_wr7();
        t_rd7();
        t_wr10();
        t_rd10();
        t_hold();
        t_anack();
        t_dnack();
        t_arb();
        t_txstall();
        t_rxfull();
        t_cancel();
        t_fifo();
        t_zero();
        summary();
    end
endmodule